// File: doc/BRIEF.md
# Invalidation-Table Last-Writer Selector

This block is the bank-select stage of a memory with several write ports and several read ports, where every write port owns its own data bank. For every address it works out which write port wrote last, so that each read port knows which data bank holds the current word. It does this without keeping a shared table that records port numbers. Each write port has its own small table bank, with one port for writing. When a port writes an address, it reads what the other ports' banks hold at that address. From those values it builds an entry that overrules all of them and stores it in its own bank. A read port reads every bank at its address and finds the one entry that no other entry overrules. The index of that bank is the selector.

Two codings are available through a parameter. In the binary coding each entry is ceil(log2(NW)) bits wide. A writer k stores k XOR the other banks' entries, so the XOR of all entries at an address is the last writer. In the one-hot coding each entry has one bit for each other bank. For a pair i<j, bank i counts as newer when the two bits that face each other are equal, and bank j counts as newer when they differ. A writer sets its bits so that every pair it belongs to resolves in its favour. The selector is the bank that wins all of its pairs.

The feedback read is synchronous, so an entry is committed one cycle after its write request. During that cycle a forwarding path hands the pending entry to any read of the same bank and address, including feedback reads from a write that follows. Two ports must not write the same address in the same cycle.

Top module: `invsel_table`

## Requirements
- R1: After reset, and before any write, every read port selects bank 0 at every address.
- R2: After port k writes address A, every later read of A selects k until another port writes A.
- R3: The selector for the address presented on a read port at a clock edge appears after that edge and holds for one cycle.
- R4: A write to address A in the same cycle as a read of A is not visible to that read, which returns the earlier last writer.
- R5: When different ports write the same address in consecutive cycles, the port that wrote last is selected.
- R6: A read of A in the cycle right after a write to A already selects the new writer.
- R7: A write to one address leaves the selection at every other address unchanged.
- R8: Writes by several ports to distinct addresses in the same cycle all take effect.
- R9: The binary and one-hot codings produce identical selector sequences for identical traffic.
- R10: Every selector value is a valid bank index, below NW.
- R11: In one-hot coding, exactly one bank is uncontradicted at every read port's address.
- R12: Read ports are independent: reads of different addresses in one cycle each return their own last writer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset, clears all table banks |
| wr_en | input | NW | Write request, one bit per write port |
| wr_addr | input | NW*AW | Write addresses, port k in bits [k*AW +: AW] |
| rd_addr | input | NR*AW | Read addresses, port r in bits [r*AW +: AW] |
| rd_sel | output | NR*IDW | Last-writer bank index for each read port, port r in bits [r*IDW +: IDW] |

## Verification
A read address sampled at one rising edge has its selector due in the cycle after that edge. That selector covers every write sampled at earlier edges and none sampled at the same edge. The bench's driver applies each cycle's inputs at the falling edge. It pushes the expected selectors from its last-writer reference before folding in that cycle's writes, so writes in the read's own cycle are excluded. The monitor pops and compares those items two nanoseconds after the next rising edge, exactly one register stage later. A one-hot and a binary instance are fed the same stimulus and checked against the same items.

// File: rtl/invsel_pkg.sv
// Shared definitions for the invalidation-table selector.
// Assumes NW >= 2 wherever entry_width is used.
package invsel_pkg;

    // Coding used for the table entries.
    typedef enum logic {
        ENC_BIN    = 1'b0,
        ENC_ONEHOT = 1'b1
    } sel_enc_e;

    // Entry width for the chosen coding and number of write ports.
    function automatic int entry_width(sel_enc_e enc, int nw);
        if (enc == ENC_BIN) return (nw > 2) ? $clog2(nw) : 1;
        return nw - 1;
    endfunction

endpackage

// File: rtl/invsel_bank.sv
// One table bank: DEPTH entries of EW bits, one write port and NP
// synchronous read ports. A read at the address being written in the
// same cycle returns the new entry (forwarding), so a pending update
// is never missed. Assumes waddr and raddr are below DEPTH.
module invsel_bank #(
    parameter int DEPTH = 16,
    parameter int EW    = 2,
    parameter int NP    = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [EW-1:0]    wdata,
    input  logic [NP*AW-1:0] raddr,
    output logic [NP*EW-1:0] rdata
);

    logic [EW-1:0] mem [DEPTH];

    // Entry storage: cleared by reset, written by the owning port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NP; p++) begin : g_rd
        logic [AW-1:0] ra;
        assign ra = raddr[p*AW +: AW];

        // Registered read with forwarding of the entry being committed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdata[p*EW +: EW] <= '0;
            end else if (we && (waddr == ra)) begin
                rdata[p*EW +: EW] <= wdata;
            end else begin
                rdata[p*EW +: EW] <= mem[ra];
            end
        end
    end

endmodule

// File: rtl/invsel_fb.sv
// Feedback function of writer K: builds the entry that overrules the
// entries of every other bank at the written address. The slot of K in
// 'peers' carries no information and is not read.
module invsel_fb
    import invsel_pkg::*;
#(
    parameter int       NW  = 3,
    parameter int       K   = 0,
    parameter sel_enc_e ENC = ENC_ONEHOT,
    localparam int      EW  = entry_width(ENC, NW)
) (
    input  logic [NW*EW-1:0] peers,
    output logic [EW-1:0]    new_ent
);

    if (ENC == ENC_BIN) begin : g_bin
        // Own index folded with all other entries by XOR.
        always_comb begin
            new_ent = EW'(K);
            for (int m = 0; m < NW; m++) begin
                if (m != K) new_ent = new_ent ^ peers[m*EW +: EW];
            end
        end
    end else begin : g_oh
        // Per pair: copy the facing bit when K is lower, invert it when higher.
        always_comb begin
            new_ent = '0;
            for (int m = 0; m < NW; m++) begin
                if (m != K) begin
                    if (K < m) new_ent[m - 1] = peers[m*EW + K];
                    else       new_ent[m]     = ~peers[m*EW + K - 1];
                end
            end
        end
    end

endmodule

// File: rtl/invsel_out.sv
// Output function for one read port: takes the entries of all banks at
// the read address and returns the bank that nobody overrules, both as
// a one-hot hit vector and as an index.
module invsel_out
    import invsel_pkg::*;
#(
    parameter int       NW  = 3,
    parameter sel_enc_e ENC = ENC_ONEHOT,
    localparam int      EW  = entry_width(ENC, NW),
    localparam int      IDW = (NW > 2) ? $clog2(NW) : 1
) (
    input  logic [NW*EW-1:0] ents,
    output logic [NW-1:0]    hit,
    output logic [IDW-1:0]   sel
);

    if (ENC == ENC_BIN) begin : g_bin
        logic [EW-1:0] acc;

        // XOR of all entries is the last writer; hit is its decode.
        always_comb begin
            acc = '0;
            for (int b = 0; b < NW; b++) acc = acc ^ ents[b*EW +: EW];
            sel = acc;
            hit = '0;
            for (int b = 0; b < NW; b++) hit[b] = (acc == EW'(b));
        end
    end else begin : g_oh
        // Bank k wins when every pair it belongs to resolves towards it.
        always_comb begin
            for (int k = 0; k < NW; k++) begin
                hit[k] = 1'b1;
                for (int m = 0; m < NW; m++) begin
                    if (m > k) begin
                        hit[k] = hit[k] & (ents[k*EW + m - 1] == ents[m*EW + k]);
                    end else if (m < k) begin
                        hit[k] = hit[k] & (ents[k*EW + m] != ents[m*EW + k - 1]);
                    end
                end
            end
        end

        // Index of the winning bank.
        always_comb begin
            sel = '0;
            for (int k = 0; k < NW; k++) begin
                if (hit[k]) sel = sel | IDW'(k);
            end
        end
    end

endmodule

// File: rtl/invsel_table.sv
// Invalidation-table last-writer selector for NW write and NR read ports.
// Each write port owns a bank. A write request in cycle t reads the other
// banks (feedback); in cycle t+1 the new entry is computed and committed.
// Reads see every write requested in an earlier cycle. Assumes no two
// ports write the same address in the same cycle.
module invsel_table
    import invsel_pkg::*;
#(
    parameter int       NW    = 3,
    parameter int       NR    = 2,
    parameter int       DEPTH = 16,
    parameter sel_enc_e ENC   = ENC_ONEHOT,
    localparam int      AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int      IDW   = (NW > 2) ? $clog2(NW) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NW-1:0]     wr_en,
    input  logic [NW*AW-1:0]  wr_addr,
    input  logic [NR*AW-1:0]  rd_addr,
    output logic [NR*IDW-1:0] rd_sel
);

    localparam int EW = entry_width(ENC, NW);
    localparam int NP = NW - 1 + NR;

    logic [NW-1:0]     upd_v;
    logic [NW*AW-1:0]  upd_a;
    logic [NP*AW-1:0]  bank_ra [NW];
    logic [NP*EW-1:0]  bank_rd [NW];
    logic [NW*EW-1:0]  fb_vec  [NW];
    logic [NW*EW-1:0]  rd_ents [NR];
    logic [EW-1:0]     new_ent [NW];
    logic [NR*NW-1:0]  rd_hit;

    // Write request pipeline: address held while feedback returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_v <= '0;
            upd_a <= '0;
        end else begin
            upd_v <= wr_en;
            upd_a <= wr_addr;
        end
    end

    // Bank read addresses: feedback ports first, then the read ports.
    always_comb begin
        for (int b = 0; b < NW; b++) begin
            for (int p = 0; p < NW - 1; p++) begin
                bank_ra[b][p*AW +: AW] = wr_addr[((p < b) ? p : p + 1)*AW +: AW];
            end
            for (int r = 0; r < NR; r++) begin
                bank_ra[b][(NW - 1 + r)*AW +: AW] = rd_addr[r*AW +: AW];
            end
        end
    end

    // Gather, for each writer, the other banks' feedback entries.
    always_comb begin
        for (int k = 0; k < NW; k++) begin
            fb_vec[k] = '0;
            for (int m = 0; m < NW; m++) begin
                if (m != k) begin
                    fb_vec[k][m*EW +: EW] = bank_rd[m][((k < m) ? k : k - 1)*EW +: EW];
                end
            end
        end
    end

    // Gather, for each read port, the entries of all banks.
    always_comb begin
        for (int r = 0; r < NR; r++) begin
            for (int b = 0; b < NW; b++) begin
                rd_ents[r][b*EW +: EW] = bank_rd[b][(NW - 1 + r)*EW +: EW];
            end
        end
    end

    for (genvar k = 0; k < NW; k++) begin : g_wr
        invsel_fb #(
            .NW  (NW),
            .K   (k),
            .ENC (ENC)
        ) u_fb (
            .peers   (fb_vec[k]),
            .new_ent (new_ent[k])
        );

        invsel_bank #(
            .DEPTH (DEPTH),
            .EW    (EW),
            .NP    (NP)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (upd_v[k]),
            .waddr (upd_a[k*AW +: AW]),
            .wdata (new_ent[k]),
            .raddr (bank_ra[k]),
            .rdata (bank_rd[k])
        );
    end

    for (genvar r = 0; r < NR; r++) begin : g_rd
        invsel_out #(
            .NW  (NW),
            .ENC (ENC)
        ) u_out (
            .ents (rd_ents[r]),
            .hit  (rd_hit[r*NW +: NW]),
            .sel  (rd_sel[r*IDW +: IDW])
        );
    end

endmodule

// File: rtl/invsel_table_chk.sv
// Property checker for invsel_table, attached by bind below. Assumes
// the same traffic rule as the design: no two ports write one address
// in the same cycle.
module invsel_table_chk
    import invsel_pkg::*;
#(
    parameter int       NW    = 3,
    parameter int       NR    = 2,
    parameter int       DEPTH = 16,
    parameter sel_enc_e ENC   = ENC_ONEHOT,
    localparam int      AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int      IDW   = (NW > 2) ? $clog2(NW) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NW-1:0]     wr_en,
    input logic [NW*AW-1:0]  wr_addr,
    input logic [NR*AW-1:0]  rd_addr,
    input logic [NR*IDW-1:0] rd_sel,
    input logic [NR*NW-1:0]  rd_hit
);

    AST_RESET_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rd_sel == '0)); // R1

    for (genvar r = 0; r < NR; r++) begin : g_r
        if ((1 << IDW) != NW) begin : g_rng
            AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
                (int'(rd_sel[r*IDW +: IDW]) < NW)); // R10
        end

        if (ENC == ENC_ONEHOT) begin : g_one
            AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
                ($countones(rd_hit[r*NW +: NW]) == 1)); // R11
        end

        for (genvar k = 0; k < NW; k++) begin : g_k
            AST_FWD_NEW_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(wr_en[k]) && (rd_addr[r*AW +: AW] == $past(wr_addr[k*AW +: AW])))
                |=> (int'(rd_sel[r*IDW +: IDW]) == k)); // R6
        end
    end

endmodule

bind invsel_table invsel_table_chk #(
    .NW    (NW),
    .NR    (NR),
    .DEPTH (DEPTH),
    .ENC   (ENC)
) u_chk (.*);

// File: tb/sim_invsel_table.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected selectors from a
// last-writer reference, the monitor pops them one edge later and
// compares both codings.
module sim_invsel_table;
    import invsel_pkg::*;

    localparam int NW    = 3;
    localparam int NR    = 2;
    localparam int DEPTH = 16;
    localparam int AW    = 4;
    localparam int IDW   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NW-1:0]     wr_en = '0;
    logic [NW*AW-1:0]  wr_addr = '0;
    logic [NR*AW-1:0]  rd_addr = '0;
    logic [NR*IDW-1:0] sel_oh;
    logic [NR*IDW-1:0] sel_bin;

    always #4 clk = ~clk;

    invsel_table #(.NW(NW), .NR(NR), .DEPTH(DEPTH), .ENC(ENC_ONEHOT)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .rd_addr(rd_addr), .rd_sel(sel_oh));

    invsel_table #(.NW(NW), .NR(NR), .DEPTH(DEPTH), .ENC(ENC_BIN)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .rd_addr(rd_addr), .rd_sel(sel_bin));

    typedef struct {
        int    port;
        int    exp;
        string tag;
    } item_t;

    item_t q[$];
    item_t mon_it;
    int    checks = 0;
    int    errors = 0;
    int    ref_tab [DEPTH];

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One cycle of traffic: drive, push expectations, then update reference.
    task automatic step(input logic [NW-1:0] we, input int wa[NW],
                        input int ra[NR], input string tag);
        @(negedge clk);
        wr_en = we;
        for (int k = 0; k < NW; k++) wr_addr[k*AW +: AW] = AW'(wa[k]);
        for (int r = 0; r < NR; r++) begin
            rd_addr[r*AW +: AW] = AW'(ra[r]);
            q.push_back('{r, ref_tab[ra[r]], tag});
        end
        for (int k = 0; k < NW; k++) if (we[k]) ref_tab[wa[k]] = k;
    endtask

    // Monitor: compare every due item shortly after the rising edge.
    always @(posedge clk) begin
        #2;
        while (q.size() > 0) begin
            mon_it = q.pop_front();
            check(mon_it.tag, int'(sel_oh[mon_it.port*IDW +: IDW]), mon_it.exp);
            check({"R9 ", mon_it.tag}, int'(sel_bin[mon_it.port*IDW +: IDW]), mon_it.exp);
            check("R10", int'(int'(sel_oh[mon_it.port*IDW +: IDW]) < NW), 1);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) ref_tab[a] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: untouched addresses select bank 0
        step(3'b000, '{0, 0, 0}, '{0, 5}, "R1");
        step(3'b000, '{0, 0, 0}, '{15, 9}, "R1");
        // R6: read right after the write cycle sees port 1
        step(3'b010, '{0, 4, 0}, '{0, 3}, "R1");
        step(3'b000, '{0, 0, 0}, '{4, 4}, "R6");
        // R4: same-cycle write to 7 is invisible; then R2 sees it
        step(3'b100, '{0, 0, 7}, '{7, 4}, "R4");
        step(3'b000, '{0, 0, 0}, '{7, 7}, "R2");
        // R5: three ports hit address 9 in consecutive cycles
        step(3'b001, '{9, 0, 0}, '{9, 2}, "R5");
        step(3'b100, '{0, 0, 9}, '{9, 2}, "R5");
        step(3'b010, '{0, 9, 0}, '{9, 3}, "R5");
        step(3'b000, '{0, 0, 0}, '{9, 9}, "R5");
        // R8: three distinct-address writes in one cycle
        step(3'b111, '{1, 2, 3}, '{1, 2}, "R8");
        step(3'b000, '{0, 0, 0}, '{3, 1}, "R8");
        step(3'b000, '{0, 0, 0}, '{2, 4}, "R8");
        // R7: writes elsewhere leave 4 and 7 alone
        step(3'b001, '{10, 0, 0}, '{4, 7}, "R7");
        step(3'b010, '{0, 11, 0}, '{4, 7}, "R7");
        step(3'b000, '{0, 0, 0}, '{10, 11}, "R7");
        // R12 and R11: independent ports, single uncontradicted bank
        step(3'b000, '{0, 0, 0}, '{9, 3}, "R12");
        step(3'b000, '{0, 0, 0}, '{2, 10}, "R11");

        // R3: random traffic, distinct write addresses per cycle
        for (int n = 0; n < 3000; n++) begin
            logic [NW-1:0] we;
            int wa[NW];
            int ra[NR];
            we = NW'($urandom);
            for (int k = 0; k < NW; k++) begin
                bit clash;
                do begin
                    wa[k] = $urandom_range(0, 7);
                    clash = 1'b0;
                    for (int j = 0; j < k; j++) if (wa[j] == wa[k]) clash = 1'b1;
                end while (clash);
            end
            for (int r = 0; r < NR; r++) ra[r] = $urandom_range(0, 7);
            step(we, wa, ra, "R3");
        end

        @(negedge clk);
        wr_en = '0;
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule